// File: doc/BRIEF.md
# Compare-Match Timer Channel

One timer channel built around an up-counter that is paced by a selectable division of a slow reference tick. When the counter reaches the value in the compare register, the next counting tick returns it to zero and raises a sticky match flag. In the wide build, a rollover from all-ones to zero that is not a compare match raises a separate overflow flag. Software reaches the control/status word, the counter and the compare value through a small word-addressed register port. An external start input gates counting.

A parameter selects either a 16-bit build or a 32-bit build. The two builds have different control/status layouts, different clock-select codes and different counter widths. A write to the counter does not take effect at once. It is held pending and is applied only after two slow reference ticks. Until then, reads and counting both keep using the old value. The interrupt request follows the match flag, gated by the enable bit and, in the wide build, also by a request-routing field.

Top module: `cmt_channel`

## Requirements
- R1: Word address 0 selects the control/status register, address 1 selects the counter and address 2 selects the compare register. After reset, the control/status word and the counter read 0 and the compare register reads all-ones.
- R2: In the 32-bit build, clock-select bits [2:0] pace the counter at one count per 8 slow ticks for code 4, per 32 for code 5, per 128 for code 6 and per 1 for code 7.
- R3: In the 16-bit build, clock-select bits [1:0] pace the counter at one count per 8, 32, 128 or 512 slow ticks for codes 0, 1, 2 and 3.
- R4: On a counting tick where the counter equals the compare value, the counter becomes 0 and the match flag sets, so one period is the compare value plus 1 counts. The match flag is bit 15 in the 32-bit build and bit 7 in the 16-bit build.
- R5: In the 32-bit build, a counting tick that takes the counter from all-ones to zero without a compare match sets the overflow flag at bit 14 and leaves the match flag unchanged.
- R6: A control/status write clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. All other fields take the written value and read back.
- R7: A counter write is not visible to reads or to counting until two slow ticks have passed after the write. Bus cycles without a slow tick do not advance this delay.
- R8: While start is low, the counter holds its value and the prescaler restarts.
- R9: The interrupt request is high exactly when the match flag is set and the enable bit is set (bit 7 in the 32-bit build, bit 6 in the 16-bit build). In the 32-bit build the routing field at bits [5:4] must also equal 2.
- R10: Writing 0 to the control/status register drops the interrupt request and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle pulse per slow reference clock period |
| start_i | input | 1 | Counting enable |
| sel_i | input | 2 | Register word address |
| wr_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that slow_tick_i is a synchronous pulse in the bus clock domain. They also assume that a counter write is not followed by a conflicting counting tick in the same cycle, unless the property excludes that case explicitly. The bench holds slow_tick_i high or low for whole bus cycles and changes all inputs on the falling edge. It writes the counter and the compare register only while start is low, so every expected count follows from whole numbers of prescaled ticks.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam logic [1:0] ADDR_CSR = 2'd0;
  localparam logic [1:0] ADDR_CNT = 2'd1;
  localparam logic [1:0] ADDR_CMP = 2'd2;
  localparam logic [1:0] ROUTE_IRQ = 2'd2;
  localparam int PRE_W = 9;

  typedef struct packed {
    logic       match;
    logic       ovf;
    logic       cmm;
    logic       ie;
    logic [1:0] route;
    logic [2:0] cks;
  } csr_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slow_tick_i,
  input  logic       run_i,
  input  logic [2:0] cks_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] lim;
  logic [PRE_W-1:0] pre_q;

  generate
    if (WIDE) begin : g_wide
      always_comb begin
        unique case (cks_i[1:0])
          2'd0:    lim = PRE_W'(7);
          2'd1:    lim = PRE_W'(31);
          2'd2:    lim = PRE_W'(127);
          default: lim = '0;
        endcase
      end
    end else begin : g_narrow
      always_comb begin
        unique case (cks_i[1:0])
          2'd0:    lim = PRE_W'(7);
          2'd1:    lim = PRE_W'(31);
          2'd2:    lim = PRE_W'(127);
          default: lim = PRE_W'(511);
        endcase
      end
    end
  endgenerate

  assign tick_o = run_i & slow_tick_i & (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (!run_i)      pre_q <= '0;
    else if (slow_tick_i) pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             slow_tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             wrap_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q, pend_val_q;
  logic [1:0]       pend_q;

  // pending write lands on the second slow tick; a fresh write restarts it
  assign load_o  = (pend_q == 2'd1) & slow_tick_i & ~wr_i;
  assign match_o = tick_i & ~load_o & (cnt_q == cmp_i);
  assign wrap_o  = tick_i & ~load_o & (cnt_q != cmp_i) & (&cnt_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_val_q <= '0;
    end else if (wr_i) begin
      pend_q     <= 2'd2;
      pend_val_q <= wdata_i;
    end else if (slow_tick_i && pend_q != 2'd0) begin
      pend_q     <= pend_q - 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_o)  cnt_q <= pend_val_q;
    else if (match_o) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cmt_csr.sv
module cmt_csr
  import cmt_pkg::*;
#(
  parameter bit WIDE   = 1'b1,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              match_set_i,
  input  logic              ovf_set_i,
  output csr_t              csr_o,
  output logic [DATA_W-1:0] rdata_o
);
  csr_t csr_q, wr_val;

  generate
    if (WIDE) begin : g_wide
      always_comb begin
        wr_val       = '0;
        wr_val.match = wdata_i[15];
        wr_val.ovf   = wdata_i[14];
        wr_val.cmm   = wdata_i[8];
        wr_val.ie    = wdata_i[7];
        wr_val.route = wdata_i[5:4];
        wr_val.cks   = wdata_i[2:0];
        rdata_o        = '0;
        rdata_o[15]    = csr_q.match;
        rdata_o[14]    = csr_q.ovf;
        rdata_o[8]     = csr_q.cmm;
        rdata_o[7]     = csr_q.ie;
        rdata_o[5:4]   = csr_q.route;
        rdata_o[2:0]   = csr_q.cks;
      end
    end else begin : g_narrow
      always_comb begin
        wr_val       = '0;
        wr_val.match = wdata_i[7];
        wr_val.ie    = wdata_i[6];
        wr_val.cks   = {1'b0, wdata_i[1:0]};
        rdata_o      = '0;
        rdata_o[7]   = csr_q.match;
        rdata_o[6]   = csr_q.ie;
        rdata_o[1:0] = csr_q.cks[1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= '0;
    end else begin
      if (wr_i) begin
        csr_q.cmm   <= wr_val.cmm;
        csr_q.ie    <= wr_val.ie;
        csr_q.route <= wr_val.route;
        csr_q.cks   <= wr_val.cks;
      end
      // event set wins over a same-cycle write-zero clear
      csr_q.match <= match_set_i | (csr_q.match & (~wr_i | wr_val.match));
      csr_q.ovf   <= WIDE & (ovf_set_i | (csr_q.ovf & (~wr_i | wr_val.ovf)));
    end
  end

  assign csr_o = csr_q;
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter bit WIDE   = 1'b1,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              start_i,
  input  logic [1:0]        sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = WIDE ? 32 : 16;

  csr_t              csr;
  logic [DATA_W-1:0] csr_rdata;
  logic [CNT_W-1:0]  cnt_q, cmp_q;
  logic              cnt_tick, load_fire, match_set, ovf_set;
  logic              cnt_wr, csr_wr, cmp_wr;
  logic              match_q, ovf_q, ie_q;

  assign csr_wr = wr_i & (sel_i == ADDR_CSR);
  assign cnt_wr = wr_i & (sel_i == ADDR_CNT);
  assign cmp_wr = wr_i & (sel_i == ADDR_CMP);

  cmt_prescaler #(.WIDE(WIDE)) i_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slow_tick_i(slow_tick_i),
    .run_i      (start_i),
    .cks_i      (csr.cks),
    .tick_o     (cnt_tick)
  );

  cmt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (cnt_tick),
    .slow_tick_i(slow_tick_i),
    .wr_i       (cnt_wr),
    .wdata_i    (wdata_i[CNT_W-1:0]),
    .cmp_i      (cmp_q),
    .cnt_o      (cnt_q),
    .match_o    (match_set),
    .wrap_o     (ovf_set),
    .load_o     (load_fire)
  );

  cmt_csr #(.WIDE(WIDE), .DATA_W(DATA_W)) i_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (csr_wr),
    .wdata_i    (wdata_i),
    .match_set_i(match_set),
    .ovf_set_i  (ovf_set),
    .csr_o      (csr),
    .rdata_o    (csr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '1;
    else if (cmp_wr) cmp_q <= wdata_i[CNT_W-1:0];
  end

  assign match_q = csr.match;
  assign ovf_q   = csr.ovf;
  assign ie_q    = csr.ie;

  generate
    if (WIDE) begin : g_irq_wide
      assign irq_o = match_q & ie_q & (csr.route == ROUTE_IRQ);
    end else begin : g_irq_narrow
      assign irq_o = match_q & ie_q;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      ADDR_CSR: rdata_o = csr_rdata;
      ADDR_CNT: rdata_o[CNT_W-1:0] = cnt_q;
      ADDR_CMP: rdata_o[CNT_W-1:0] = cmp_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
  parameter bit WIDE   = 1'b1,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic              match_q,
  input logic              ovf_q,
  input logic              ie_q,
  input logic              cnt_tick,
  input logic              load_fire,
  input logic              match_set,
  input logic              cnt_wr,
  input logic              csr_wr,
  input logic [DATA_W-1:0] wdata_i
);
  localparam int MATCH_POS = WIDE ? 15 : 7;

  assert_hold_stopped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !load_fire) |=> $stable(cnt_q));

  assert_match_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_tick && !load_fire && cnt_q == cmp_q) |=> (cnt_q == '0 && match_q));

  assert_rollover_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WIDE && cnt_tick && !load_fire && cnt_q != cmp_q && (&cnt_q)) |=> ovf_q);

  assert_write_deferred_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr && !cnt_tick) |=> $stable(cnt_q));

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (match_q && ie_q));

  assert_zero_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr && wdata_i == '0) |=> !irq_o);

  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr && !wdata_i[MATCH_POS] && !match_set) |=> !match_q);
endmodule

bind cmt_channel cmt_channel_chk #(.WIDE(WIDE), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .irq_o    (irq_o),
  .cnt_q    (cnt_q),
  .cmp_q    (cmp_q),
  .match_q  (match_q),
  .ovf_q    (ovf_q),
  .ie_q     (ie_q),
  .cnt_tick (cnt_tick),
  .load_fire(load_fire),
  .match_set(match_set),
  .cnt_wr   (cnt_wr),
  .csr_wr   (csr_wr),
  .wdata_i  (wdata_i)
);

// File: tb/test_cmt_channel.sv
`timescale 1ns/1ps
module test_cmt_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow = 1'b1;
  logic        start = 1'b0, start16 = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        wr = 1'b0, wr16 = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata16;
  logic        irq, irq16;
  int          nchk = 0, nerr = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cmt_channel #(.WIDE(1'b1)) i_cmt_channel (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .start_i(start),
    .sel_i(sel), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  cmt_channel #(.WIDE(1'b0)) i_cmt_channel_16 (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .start_i(start16),
    .sel_i(sel), .wr_i(wr16), .wdata_i(wdata), .rdata_o(rdata16), .irq_o(irq16));

  typedef struct packed {
    logic [2:0]  cks;
    logic [31:0] cmp;
    logic [15:0] k;
    logic [31:0] cnt;
    logic        m;
  } vec_t;

  // cks code, compare, enabled edges, expected count, expected match
  localparam vec_t VEC [8] = '{
    '{3'd7, 32'd9,   16'd5,   32'd5, 1'b0},
    '{3'd7, 32'd9,   16'd10,  32'd0, 1'b1},
    '{3'd7, 32'd9,   16'd13,  32'd3, 1'b1},
    '{3'd4, 32'd3,   16'd20,  32'd2, 1'b0},
    '{3'd4, 32'd3,   16'd40,  32'd1, 1'b1},
    '{3'd5, 32'd100, 16'd100, 32'd3, 1'b0},
    '{3'd6, 32'd1,   16'd300, 32'd0, 1'b1},
    '{3'd7, 32'd0,   16'd3,   32'd0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wreg(input bit narrow, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = a; wdata = d;
    if (narrow) wr16 = 1'b1; else wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0; wr16 = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d, output logic [31:0] d16);
    @(negedge clk);
    sel = a; #1;
    d = rdata; d16 = rdata16;
  endtask

  task automatic run(input bit narrow, input int k);
    @(negedge clk);
    if (narrow) start16 = 1'b1; else start = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk);
    start = 1'b0; start16 = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d, d16, held;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state and register map
    rreg(2'd0, d, d16); chk("R1 csr reset", d, 32'h0); chk("R1 csr16 reset", d16, 32'h0);
    rreg(2'd1, d, d16); chk("R1 cnt reset", d, 32'h0);
    rreg(2'd2, d, d16); chk("R1 cmp reset", d, 32'hFFFF_FFFF); chk("R1 cmp16 reset", d16, 32'h0000_FFFF);
    chk("R9 irq reset", {31'b0, irq}, 32'h0);
    wreg(1'b0, 2'd2, 32'h1234_5678);
    rreg(2'd2, d, d16); chk("R1 cmp readback", d, 32'h1234_5678);

    // R2 R4 vector walk
    foreach (VEC[i]) begin
      wreg(1'b0, 2'd2, VEC[i].cmp);
      wreg(1'b0, 2'd0, {29'b0, VEC[i].cks});
      wreg(1'b0, 2'd1, 32'h0);
      repeat (3) @(posedge clk);
      run(1'b0, int'(VEC[i].k));
      rreg(2'd1, d, d16); chk($sformatf("R2 R4 vec%0d count", i), d, VEC[i].cnt);
      rreg(2'd0, d, d16); chk($sformatf("R4 vec%0d match", i), {31'b0, d[15]}, {31'b0, VEC[i].m});
    end

    // R8 counter holds while stopped
    rreg(2'd1, held, d16);
    repeat (10) @(posedge clk);
    rreg(2'd1, d, d16); chk("R8 hold", d, held);

    // R7 two slow ticks before a counter write lands
    wreg(1'b0, 2'd1, 32'd50);
    @(negedge clk); #1; chk("R7 pending 1", rdata, held);
    @(negedge clk); #1; chk("R7 pending 2", rdata, held);
    @(negedge clk); #1; chk("R7 landed", rdata, 32'd50);
    @(negedge clk) slow = 1'b0;
    wreg(1'b0, 2'd1, 32'd77);
    repeat (5) @(posedge clk);
    rreg(2'd1, d, d16); chk("R7 no slow tick", d, 32'd50);
    @(negedge clk) slow = 1'b1;
    repeat (2) @(posedge clk);
    rreg(2'd1, d, d16); chk("R7 after slow ticks", d, 32'd77);

    // R5 rollover without compare match
    wreg(1'b0, 2'd2, 32'd5);
    wreg(1'b0, 2'd0, 32'h7);
    wreg(1'b0, 2'd1, 32'hFFFF_FFFE);
    repeat (3) @(posedge clk);
    run(1'b0, 2);
    rreg(2'd1, d, d16); chk("R5 wrapped count", d, 32'h0);
    rreg(2'd0, d, d16); chk("R5 ovf set", {31'b0, d[14]}, 32'h1); chk("R5 no match", {31'b0, d[15]}, 32'h0);

    // R6 write-zero clears only the zeroed flag
    run(1'b0, 6);
    rreg(2'd0, d, d16); chk("R6 both flags", {30'b0, d[15:14]}, 32'h3);
    wreg(1'b0, 2'd0, 32'h0000_8107);
    rreg(2'd0, d, d16); chk("R6 ovf cleared match kept", d, 32'h0000_8107);

    // R9 interrupt gating, R10 zero write
    wreg(1'b0, 2'd0, 32'h0000_80A7);
    @(negedge clk); #1; chk("R9 irq routed", {31'b0, irq}, 32'h1);
    wreg(1'b0, 2'd0, 32'h0000_8097);
    @(negedge clk); #1; chk("R9 route dma", {31'b0, irq}, 32'h0);
    wreg(1'b0, 2'd0, 32'h0000_80A7);
    wreg(1'b0, 2'd0, 32'h0);
    @(negedge clk); #1; chk("R10 irq dropped", {31'b0, irq}, 32'h0);
    rreg(2'd0, d, d16); chk("R10 csr zero", d, 32'h0);

    // R3 narrow build divide by 512, match bit 7, enable bit 6
    wreg(1'b1, 2'd2, 32'd2);
    wreg(1'b1, 2'd0, 32'h0000_0043);
    run(1'b1, 1100);
    rreg(2'd1, d, d16); chk("R3 narrow count", d16, 32'd2);
    rreg(2'd0, d, d16); chk("R3 narrow csr", d16, 32'h0000_0043);
    chk("R9 narrow irq low", {31'b0, irq16}, 32'h0);
    run(1'b1, 512);
    rreg(2'd1, d, d16); chk("R3 R4 narrow wrap", d16, 32'd0);
    rreg(2'd0, d, d16); chk("R4 narrow match", d16, 32'h0000_00C3);
    chk("R9 narrow irq", {31'b0, irq16}, 32'h1);

    summary();
  end
endmodule